// File: doc/BRIEF.md
# Byte-Serial AES-128 Encryption Core

This block encrypts one 128-bit block with a 128-bit key under AES-128. Logic area comes first, so the whole datapath is a single byte wide. Plaintext and key bytes arrive together as a stream of sixteen paired beats. The core then runs the initial key addition and ten rounds, handling one state byte per clock. The ciphertext leaves as a sixteen-beat byte stream.

One substitution table serves two users at different times: the state bytes during the byte-substitution pass, and the last key word during on-the-fly key expansion. The row rotation of each round is not a separate step. It happens in the connections of the state register when the substitution pass finishes. Column mixing gathers one column into four small registers, one byte at a time, and writes the four mixed bytes back one at a time.

Software or a host controller pulses `start` while the core is idle. It then streams in the block and drains the result. `busy` covers the whole job, and `done` marks its end. Both byte streams use valid/ready. On the input side the core is always ready during the load phase and never outside it, so `in_valid` alone sets the pace. On the output side the core holds `out_valid` and `out_data` steady until `out_ready` accepts each byte, so the sink can stall for any number of cycles.

Top module: `aes8_core`

## Requirements
- R1: After reset, `busy`, `done`, `in_ready` and `out_valid` are all low.
- R2: A `start` pulse while idle raises `busy` and `in_ready` on the next cycle. A beat is taken on each clock edge where `in_valid` and `in_ready` are both high, and exactly sixteen beats are taken. Byte k of the block is beat k, in column-major order (byte k sits at row k mod 4, column k div 4). Byte 0 is the most significant byte of the 128-bit value.
- R3: The ciphertext equals AES-128 encryption of the loaded plaintext under the loaded key. For example, key 000102…0f with plaintext 00112233…ff gives 69c4e0d86a7b0430d8cdb78070b4c55a.
- R4: The output is sixteen beats with `out_valid` high, byte 0 first, in the same byte order as R2. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` stay unchanged on the next cycle.
- R5: `done` is high for exactly one cycle. That cycle is the one after the edge that accepts the sixteenth output byte, and `busy` is already low in it.
- R6: A `start` pulse while `busy` is high has no effect. The running job finishes with the correct result and the same latency, and the core returns to idle with `in_ready` low.
- R7: `in_ready` is high only in the load phase and `out_valid` only in the output phase. The two are never high together.
- R8: `out_valid` first rises exactly 504 clock edges after the edge that accepts the sixteenth input beat, whatever the input gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a job; ignored unless idle |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Core accepts an input beat |
| in_data | input | 8 | Plaintext byte |
| in_key | input | 8 | Key byte paired with `in_data` |
| out_valid | output | 1 | Ciphertext byte present |
| out_ready | input | 1 | Sink accepts the ciphertext byte |
| out_data | output | 8 | Ciphertext byte |

## Verification
Two things are hard to reach from the ports. The first is the timing of a `start` that lands in the middle of a long computation. The second is an output stall that falls on the very last byte, right next to the `done` pulse. The bench gets there by driving random load gaps and random `out_ready` back-pressure from a fixed seed. It pulses `start` at a fixed cycle deep inside one job, and it checks every result against a separate bench model of the cipher. Directed blocks cover the known-answer vector and the all-zero and all-one extremes.

// File: rtl/aes8_pkg.sv
package aes8_pkg;
  typedef logic [7:0] byte_t;
  typedef enum logic [2:0] {PH_IDLE, PH_LOAD, PH_KEY, PH_SUB, PH_MIX, PH_ARK, PH_OUT} phase_t;

  function automatic byte_t xtime(input byte_t a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic byte_t gmul(input byte_t a, input byte_t b);
    byte_t p = 8'h00;
    byte_t x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = xtime(x);
    end
    return p;
  endfunction

  // Inverse as x^254, then the affine map; evaluated on constants only.
  function automatic byte_t sbox_val(input byte_t x);
    byte_t x2, x3, x12, x15, x240, v;
    x2   = gmul(x, x);
    x3   = gmul(x2, x);
    x12  = gmul(gmul(x3, x3), gmul(x3, x3));
    x15  = gmul(x12, x3);
    x240 = gmul(gmul(gmul(x15, x15), gmul(x15, x15)), gmul(gmul(x15, x15), gmul(x15, x15)));
    x240 = gmul(x240, x240);
    v    = gmul(gmul(x240, x12), x2);
    return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]} ^ {v[3:0], v[7:4]} ^ 8'h63;
  endfunction

  // Source position feeding state position j after the row rotation.
  function automatic int sr_src(input int j);
    return (j % 4) + 4 * (((j / 4) + (j % 4)) % 4);
  endfunction
endpackage

// File: rtl/aes8_sbox.sv
module aes8_sbox
  import aes8_pkg::*;
#(
  parameter int ENTRIES = 256
) (
  input  byte_t addr,
  output byte_t data
);
  byte_t rom [ENTRIES];
  for (genvar g = 0; g < ENTRIES; g++) begin : g_rom
    assign rom[g] = sbox_val(byte_t'(g));
  end
  assign data = rom[addr];
endmodule

// File: rtl/aes8_mixcol.sv
module aes8_mixcol
  import aes8_pkg::*;
#(
  parameter int ROWS = 4
) (
  input  logic       clk,
  input  logic       feed,
  input  byte_t      din,
  input  logic [1:0] row,
  output byte_t      dout
);
  byte_t col [ROWS];
  logic [1:0] r1, r2, r3;

  always_ff @(posedge clk) begin
    if (feed) begin
      for (int i = 0; i < ROWS - 1; i++) col[i] <= col[i + 1];
      col[ROWS - 1] <= din;
    end
  end

  always_comb begin
    r1 = row + 2'd1;
    r2 = row + 2'd2;
    r3 = row + 2'd3;
    dout = xtime(col[row]) ^ xtime(col[r1]) ^ col[r1] ^ col[r2] ^ col[r3];
  end
endmodule

// File: rtl/aes8_core.sv
module aes8_core
  import aes8_pkg::*;
#(
  parameter int NB = 16,
  parameter int NR = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output logic       busy,
  output logic       done,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic [7:0] in_key,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data
);
  localparam int IW = $clog2(NB);
  localparam int CW = $clog2(2 * NB);
  localparam int RW = $clog2(NR + 1);

  phase_t        ph;
  logic [CW-1:0] cnt;
  logic [RW-1:0] rnd;
  byte_t         rcon;
  byte_t         st [NB];
  byte_t         rk [NB];
  byte_t         sub_nx [NB];
  byte_t         sb_in, sb_out, mc_out;
  logic [1:0]    rot_sel;
  logic [IW-1:0] kw_idx, ki_key, ki_fin, ki_mix, st_wr;
  logic          mc_feed;

  aes8_sbox u_sbox (.addr(sb_in), .data(sb_out));

  assign mc_feed = (ph == PH_MIX) && !cnt[2];
  aes8_mixcol u_mix (.clk(clk), .feed(mc_feed), .din(st[0]), .row(cnt[1:0]), .dout(mc_out));

  always_comb begin
    rot_sel = cnt[1:0] + 2'd1;
    kw_idx  = IW'(NB - 4) + IW'(rot_sel);
    ki_key  = IW'(cnt[1:0]);
    ki_fin  = cnt[IW-1:0] + IW'(4);
    ki_mix  = {cnt[CW-1:3], cnt[1:0]};
    st_wr   = IW'(NB - 4) + IW'(cnt[1:0]);
    sb_in   = (ph == PH_KEY) ? rk[kw_idx] : st[0];
    for (int i = 0; i < NB - 1; i++) sub_nx[i] = st[i + 1];
    sub_nx[NB - 1] = sb_out;
  end

  assign busy      = (ph != PH_IDLE);
  assign in_ready  = (ph == PH_LOAD);
  assign out_valid = (ph == PH_OUT);
  assign out_data  = st[0];

  // Sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph   <= PH_IDLE;
      cnt  <= '0;
      rnd  <= '0;
      rcon <= 8'h01;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (ph)
        PH_IDLE: if (start) begin ph <= PH_LOAD; cnt <= '0; end
        PH_LOAD: if (in_valid) begin
          if (cnt == CW'(NB - 1)) begin
            ph <= PH_KEY; cnt <= '0; rnd <= RW'(1); rcon <= 8'h01;
          end else cnt <= cnt + 1'b1;
        end
        PH_KEY: if (cnt == CW'(3)) begin ph <= PH_SUB; cnt <= '0; end
                else cnt <= cnt + 1'b1;
        PH_SUB: if (cnt == CW'(NB - 1)) begin
          ph <= (rnd == RW'(NR)) ? PH_ARK : PH_MIX; cnt <= '0;
        end else cnt <= cnt + 1'b1;
        PH_MIX: if (cnt == CW'(2 * NB - 1)) begin
          ph <= PH_KEY; cnt <= '0; rnd <= rnd + 1'b1; rcon <= xtime(rcon);
        end else cnt <= cnt + 1'b1;
        PH_ARK: if (cnt == CW'(NB - 1)) begin ph <= PH_OUT; cnt <= '0; end
                else cnt <= cnt + 1'b1;
        PH_OUT: if (out_ready) begin
          if (cnt == CW'(NB - 1)) begin ph <= PH_IDLE; cnt <= '0; done <= 1'b1; end
          else cnt <= cnt + 1'b1;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  // Byte-serial datapath
  always_ff @(posedge clk) begin
    unique case (ph)
      PH_LOAD: if (in_valid) begin
        for (int i = 0; i < NB - 1; i++) begin
          st[i] <= st[i + 1];
          rk[i] <= rk[i + 1];
        end
        st[NB - 1] <= in_data ^ in_key;
        rk[NB - 1] <= in_key;
      end
      PH_KEY: rk[ki_key] <= rk[ki_key] ^ sb_out ^ ((cnt[1:0] == 2'd0) ? rcon : 8'h00);
      PH_SUB: begin
        if (cnt < CW'(NB - 4)) rk[ki_fin] <= rk[ki_fin] ^ rk[cnt[IW-1:0]];
        if (cnt == CW'(NB - 1)) begin
          for (int j = 0; j < NB; j++) st[j] <= sub_nx[sr_src(j)];
        end else begin
          for (int j = 0; j < NB; j++) st[j] <= sub_nx[j];
        end
      end
      PH_MIX: begin
        if (!cnt[2]) begin
          for (int i = 0; i < NB - 1; i++) st[i] <= st[i + 1];
          st[NB - 1] <= st[0];
        end else begin
          st[st_wr] <= mc_out ^ rk[ki_mix];
        end
      end
      PH_ARK: begin
        for (int i = 0; i < NB - 1; i++) st[i] <= st[i + 1];
        st[NB - 1] <= st[0] ^ rk[cnt[IW-1:0]];
      end
      PH_OUT: if (out_ready) begin
        for (int i = 0; i < NB - 1; i++) st[i] <= st[i + 1];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/aes8_core_chk.sv
module aes8_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data
);
  a_r4_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  a_r7_ready_valid_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r2_load_inside_job: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> busy);
  a_r2_load_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> $past(start));
  a_r6_start_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !out_valid && start |=> busy);
endmodule

bind aes8_core aes8_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/test_aes8_core.sv
module test_aes8_core;
  localparam int CLK_P = 10;
  localparam int LAT   = 504;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, in_valid = 1'b0, out_ready = 1'b0;
  logic [7:0] in_data = '0, in_key = '0;
  logic busy, done, in_ready, out_valid;
  logic [7:0] out_data;
  logic [7:0] sbt [256];
  int checks = 0, failures = 0;
  bit finished = 0;

  always #(CLK_P / 2) clk = ~clk;

  aes8_core i_aes8_core (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_key(in_key),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] xt(input logic [7:0] a);
    return a[7] ? ((a << 1) ^ 8'h1b) : (a << 1);
  endfunction

  function automatic logic [7:0] gm(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 0, x = a, y = b;
    while (y != 0) begin
      if (y[0]) p ^= x;
      x = xt(x);
      y = y >> 1;
    end
    return p;
  endfunction

  function automatic logic [7:0] make_sbox(input int x);
    logic [7:0] inv = 0, s;
    for (int y = 1; y < 256; y++) if (gm(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
    for (int i = 0; i < 8; i++)
      s[i] = inv[i] ^ inv[(i + 4) % 8] ^ inv[(i + 5) % 8] ^ inv[(i + 6) % 8] ^ inv[(i + 7) % 8];
    return s ^ 8'h63;
  endfunction

  function automatic logic [127:0] aes_ref(input logic [127:0] key, input logic [127:0] pt);
    logic [31:0] w [44];
    logic [31:0] tmp;
    logic [7:0] s [16];
    logic [7:0] t [16];
    logic [7:0] rc = 8'h01;
    logic [127:0] res;
    for (int i = 0; i < 4; i++) w[i] = key[127 - 32 * i -: 32];
    for (int i = 4; i < 44; i++) begin
      tmp = w[i - 1];
      if (i % 4 == 0) begin
        tmp = {tmp[23:0], tmp[31:24]};
        tmp = {sbt[tmp[31:24]] ^ rc, sbt[tmp[23:16]], sbt[tmp[15:8]], sbt[tmp[7:0]]};
        rc = xt(rc);
      end
      w[i] = w[i - 4] ^ tmp;
    end
    for (int i = 0; i < 16; i++) s[i] = pt[127 - 8 * i -: 8] ^ w[i / 4][31 - 8 * (i % 4) -: 8];
    for (int r = 1; r <= 10; r++) begin
      for (int c = 0; c < 4; c++)
        for (int q = 0; q < 4; q++) t[q + 4 * c] = sbt[s[q + 4 * ((c + q) % 4)]];
      for (int c = 0; c < 4; c++)
        for (int q = 0; q < 4; q++)
          if (r == 10) s[q + 4 * c] = t[q + 4 * c];
          else s[q + 4 * c] = xt(t[4 * c + q]) ^ xt(t[4 * c + (q + 1) % 4]) ^ t[4 * c + (q + 1) % 4]
                              ^ t[4 * c + (q + 2) % 4] ^ t[4 * c + (q + 3) % 4];
      for (int i = 0; i < 16; i++) s[i] ^= w[4 * r + i / 4][31 - 8 * (i % 4) -: 8];
    end
    for (int i = 0; i < 16; i++) res[127 - 8 * i -: 8] = s[i];
    return res;
  endfunction

  task automatic encrypt(input logic [127:0] key, input logic [127:0] pt, input int gap_pct,
                         input int stall_pct, input bit poke, input string tag);
    logic [127:0] ct = '0;
    logic [7:0] ob, prev = '0;
    bit stalled = 0, excl_ok = 1, rdy;
    int i = 0, j = 0, lat = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy && in_ready, "R2 load entry", {busy, in_ready}, 2'b11);
    while (i < 16) begin
      if (out_valid || !in_ready) excl_ok = 0;
      in_valid = ($urandom % 100) >= gap_pct;
      in_data  = pt[127 - 8 * i -: 8];
      in_key   = key[127 - 8 * i -: 8];
      @(negedge clk);
      if (in_valid) i++;
    end
    in_valid = 1'b0;
    while (!out_valid && lat < 2000) begin
      if (in_ready) excl_ok = 0;
      start = poke && (lat == 100);
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    chk(lat == LAT, {"R8 latency ", tag}, lat, LAT);
    chk(excl_ok, {"R7 exclusive phases ", tag}, excl_ok, 1);
    excl_ok = 1;
    while (j < 16) begin
      if (!out_valid || in_ready) excl_ok = 0;
      ob = out_data;
      if (stalled) chk(ob == prev, {"R4 stall hold ", tag}, ob, prev);
      rdy = (($urandom % 100) >= stall_pct) || (j == 15 && stalled);
      out_ready = rdy;
      @(negedge clk);
      if (rdy) begin ct[127 - 8 * j -: 8] = ob; j++; stalled = 0; end
      else begin stalled = 1; prev = ob; end
    end
    out_ready = 1'b0;
    chk(excl_ok, {"R4 sixteen valid beats ", tag}, excl_ok, 1);
    chk(done && !busy, {"R5 done with idle ", tag}, {done, busy}, 2'b10);
    chk(ct == aes_ref(key, pt), {"R3 ciphertext ", tag}, ct, aes_ref(key, pt));
    @(negedge clk);
    chk(!done && !busy && !in_ready, {"R5 R6 single pulse, idle after ", tag},
        {done, busy, in_ready}, 3'b000);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h2c91));
    for (int x = 0; x < 256; x++) sbt[x] = make_sbox(x);
    chk(aes_ref(128'h000102030405060708090a0b0c0d0e0f, 128'h00112233445566778899aabbccddeeff)
        == 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R3 bench model known answer",
        aes_ref(128'h000102030405060708090a0b0c0d0e0f, 128'h00112233445566778899aabbccddeeff),
        128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    repeat (3) @(negedge clk);
    chk(!busy && !done && !in_ready && !out_valid, "R1 reset state",
        {busy, done, in_ready, out_valid}, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !in_ready && !out_valid, "R1 idle after reset",
        {busy, done, in_ready, out_valid}, 4'b0000);
    encrypt(128'h000102030405060708090a0b0c0d0e0f, 128'h00112233445566778899aabbccddeeff, 0, 0, 0, "kat");
    encrypt('0, '0, 0, 0, 0, "zeros");
    encrypt('1, '1, 30, 50, 0, "ones");
    encrypt({$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom},
            20, 30, 1, "start while busy R6");
    for (int n = 0; n < 5; n++)
      encrypt({$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom},
              n * 15, 70 - n * 10, 0, "random");
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule